// File: doc/BRIEF.md
# Four-Edge Multi-Channel Pattern Generator

This block drives six pattern outputs for lens motor control: the lowest channels form a focus group and the remaining ones a zoom group. A shared prescaler divides the clock into position ticks, and a shared position counter sweeps through one pattern period. Each channel holds four edge times. While its group is moving, the channel starts every period at its polarity level and toggles at each distinct edge time that the position counter reaches.

A focus start strobe or a zoom start strobe begins a move that lasts a programmed number of whole periods. If no group is moving, a start takes effect at once and the timebase restarts from position zero. If the other group is moving, the new move waits for the next period boundary and keeps the shared phase. The two groups count their periods independently. A channel that is disabled, or whose group is not moving, drives a programmable idle state: high impedance, low or high.

Top module: `pwm_edge_bank`

## Requirements
- R1: While reset is asserted and after it is released with no start, both busy outputs are low and every channel drives its idle state.
- R2: The position counter advances once every `cfg_unit_div`+1 clocks and runs from 0 to `cfg_period`, so one period lasts (`cfg_period`+1)*(`cfg_unit_div`+1) clocks; it holds at 0 while no group is moving.
- R3: An active channel's level is its polarity bit inverted once for each distinct edge time less than or equal to the current position; edge k of channel c is `cfg_edge[(c*4+k)*8 +: 8]`, and edge times need not be in ascending order.
- R4: An edge time equal to another edge time of the same channel adds no toggle.
- R5: At position 0 an active channel with no edge time of 0 drives its polarity level; an edge time of 0 inverts it from the first position of the period.
- R6: A move started on an idle timebase keeps its group busy for exactly steps*(`cfg_period`+1)*(`cfg_unit_div`+1) clocks, counted from the clock edge that captures the start strobe.
- R7: A channel whose enable bit is 0, or whose group is not busy, drives its two-bit idle code from `cfg_idle[2c+1:2c]`: 00 and 11 give `pad_oe`=0 and `pad_out`=0, 01 drives low, 10 drives high.
- R8: A start strobe is ignored when its step count is 0 or when its own group is already busy or waiting.
- R9: A start arriving while the other group is moving makes its group busy at the next period boundary, after which it runs its own number of periods on the shared position counter.
- R10: Channels 0 and 1 follow the focus group; channels 2 to 5 follow the zoom group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_unit_div | input | 8 | Prescale value; one position tick every value+1 clocks |
| cfg_period | input | 8 | Last position of a period |
| cfg_edge | input | 192 | Four 8-bit edge times per channel, channel-major |
| cfg_en | input | 6 | Per-channel enable |
| cfg_pol | input | 6 | Per-channel start-of-period level |
| cfg_idle | input | 12 | Per-channel two-bit idle code |
| focus_steps | input | 8 | Period count for a focus move |
| zoom_steps | input | 8 | Period count for a zoom move |
| focus_start | input | 1 | Focus move start strobe |
| zoom_start | input | 1 | Zoom move start strobe |
| pad_out | output | 6 | Pad levels |
| pad_oe | output | 6 | Pad output enables |
| focus_busy | output | 1 | Focus move in progress |
| zoom_busy | output | 1 | Zoom move in progress |

## Verification
The bench walks every clock of each move and compares all six pads against a per-position model, so an off-by-one prescale or period length shows up as a pattern shifted in time and a wrong busy fall cycle. Channels with unsorted and duplicated edge times, and one with an edge at position 0, target a design that toggles twice on a repeated time or misses the first position. A zoom start during a focus move, followed by a second focus start, catches a design that restarts the shared counter, starts zoom mid-period or lets a re-start extend the running move. A zero-step start and a disabled channel inside a moving group check that nothing leaves its idle state.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int EDGES_PER_CH = 4;

  typedef enum logic [1:0] {
    IDLE_HIZ   = 2'b00,
    IDLE_LOW   = 2'b01,
    IDLE_HIGH  = 2'b10,
    IDLE_HIZ_B = 2'b11
  } idle_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DIVW = 8,
  parameter int CW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  input  logic [CW-1:0]   period,
  output logic [CW-1:0]   pos,
  output logic            wrap
);
  logic [DIVW-1:0] pre_q, pre_d;
  logic [CW-1:0]   pos_q, pos_d;
  logic            tick;

  assign tick = run && (pre_q == div);
  assign wrap = tick && (pos_q >= period);
  assign pos  = pos_q;

  always_comb begin
    pre_d = pre_q;
    pos_d = pos_q;
    if (!run) begin
      pre_d = '0;
      pos_d = '0;
    end else if (tick) begin
      pre_d = '0;
      pos_d = wrap ? '0 : pos_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      pos_q <= '0;
    end else begin
      pre_q <= pre_d;
      pos_q <= pos_d;
    end
  end

  // R2: a tick inside a period moves the position forward by exactly one
  a_r2_tick_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> (pos_q == $past(pos_q) + 1'b1));

  // R2: without a tick the position holds while running
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (pos_q == $past(pos_q)));
endmodule

// File: rtl/pwm_step_ctl.sv
module pwm_step_ctl #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] steps,
  input  logic          any_busy,
  input  logic          wrap,
  output logic          busy
);
  logic          busy_q, busy_d;
  logic          pend_q, pend_d;
  logic [SW-1:0] left_q, left_d;
  logic          accept;

  assign accept = start && (steps != '0) && !busy_q && !pend_q;
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    pend_d = pend_q;
    left_d = left_q;
    if (wrap) begin
      if (busy_q) begin
        if (left_q == 1) busy_d = 1'b0;
        else             left_d = left_q - 1'b1;
      end else if (pend_q) begin
        busy_d = 1'b1;
        pend_d = 1'b0;
      end
    end
    if (accept) begin
      left_d = steps;
      if (!any_busy || wrap) busy_d = 1'b1;
      else                   pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      left_q <= left_d;
    end
  end

  // R6: a move only ends at a period boundary
  a_r6_end_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(wrap));

  // R8: nothing but a boundary ends a running move, whatever the strobe does
  a_r8_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !$past(wrap)) |-> busy_q);
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
  import pwm_edge_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic                       pol,
  input  logic [1:0]                 idle,
  input  logic [EDGES_PER_CH*CW-1:0] edges,
  input  logic [CW-1:0]              pos,
  output logic                       pad_out,
  output logic                       pad_oe
);
  logic [EDGES_PER_CH-1:0] hit;
  logic                    level;
  logic                    no_zero_edge;
  idle_e                   idle_sel;

  assign idle_sel = idle_e'(idle);

  always_comb begin
    no_zero_edge = 1'b1;
    for (int k = 0; k < EDGES_PER_CH; k++) begin
      hit[k] = (edges[k*CW +: CW] <= pos);
      if (edges[k*CW +: CW] == '0) no_zero_edge = 1'b0;
      for (int j = 0; j < k; j++) begin
        if (edges[j*CW +: CW] == edges[k*CW +: CW]) hit[k] = 1'b0;
      end
    end
  end

  assign level = pol ^ (^hit);

  always_comb begin
    if (active) begin
      pad_oe  = 1'b1;
      pad_out = level;
    end else begin
      unique case (idle_sel)
        IDLE_LOW:  begin pad_oe = 1'b1; pad_out = 1'b0; end
        IDLE_HIGH: begin pad_oe = 1'b1; pad_out = 1'b1; end
        default:   begin pad_oe = 1'b0; pad_out = 1'b0; end
      endcase
    end
  end

  // R5: first position of a period without a zero edge shows the polarity
  a_r5_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pos == '0 && no_zero_edge) |-> (pad_out == pol));

  // R7: high-impedance idle codes release the pad
  a_r7_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && (idle == 2'b00 || idle == 2'b11)) |-> !pad_oe);
endmodule

// File: rtl/pwm_edge_bank.sv
module pwm_edge_bank
  import pwm_edge_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int NFOCUS = 2,
  parameter int CW     = 8,
  parameter int DIVW   = 8,
  parameter int SW     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DIVW-1:0]                cfg_unit_div,
  input  logic [CW-1:0]                  cfg_period,
  input  logic [NCH*EDGES_PER_CH*CW-1:0] cfg_edge,
  input  logic [NCH-1:0]                 cfg_en,
  input  logic [NCH-1:0]                 cfg_pol,
  input  logic [2*NCH-1:0]               cfg_idle,
  input  logic [SW-1:0]                  focus_steps,
  input  logic [SW-1:0]                  zoom_steps,
  input  logic                           focus_start,
  input  logic                           zoom_start,
  output logic [NCH-1:0]                 pad_out,
  output logic [NCH-1:0]                 pad_oe,
  output logic                           focus_busy,
  output logic                           zoom_busy
);
  localparam int CH_BITS = EDGES_PER_CH * CW;

  logic          any_busy;
  logic          wrap;
  logic [CW-1:0] pos;

  assign any_busy = focus_busy | zoom_busy;

  pwm_timebase #(.DIVW(DIVW), .CW(CW)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (any_busy),
    .div    (cfg_unit_div),
    .period (cfg_period),
    .pos    (pos),
    .wrap   (wrap)
  );

  pwm_step_ctl #(.SW(SW)) u_focus_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (focus_start),
    .steps    (focus_steps),
    .any_busy (any_busy),
    .wrap     (wrap),
    .busy     (focus_busy)
  );

  pwm_step_ctl #(.SW(SW)) u_zoom_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (zoom_start),
    .steps    (zoom_steps),
    .any_busy (any_busy),
    .wrap     (wrap),
    .busy     (zoom_busy)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic grp_busy;
    if (c < NFOCUS) begin : g_focus
      assign grp_busy = focus_busy;
    end else begin : g_zoom
      assign grp_busy = zoom_busy;
    end

    pwm_edge_chan #(.CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (cfg_en[c] & grp_busy),
      .pol     (cfg_pol[c]),
      .idle    (cfg_idle[2*c +: 2]),
      .edges   (cfg_edge[c*CH_BITS +: CH_BITS]),
      .pos     (pos),
      .pad_out (pad_out[c]),
      .pad_oe  (pad_oe[c])
    );
  end

  // R9: a group can become busy mid-period only when the timebase was idle
  a_r9_join_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(zoom_busy) && $past(focus_busy)) |-> $past(wrap));
endmodule

// File: tb/pwm_edge_bank_tb.sv
module pwm_edge_bank_tb;
  localparam int NCH = 6;

  logic          clk;
  logic          rst_n;
  logic [7:0]    cfg_unit_div;
  logic [7:0]    cfg_period;
  logic [191:0]  cfg_edge;
  logic [5:0]    cfg_en;
  logic [5:0]    cfg_pol;
  logic [11:0]   cfg_idle;
  logic [7:0]    focus_steps;
  logic [7:0]    zoom_steps;
  logic          focus_start;
  logic          zoom_start;
  logic [5:0]    pad_out;
  logic [5:0]    pad_oe;
  logic          focus_busy;
  logic          zoom_busy;

  logic [7:0] edge_t [NCH][4];
  int n_checks = 0;
  int n_errors = 0;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 4; k++)
        cfg_edge[(c*4+k)*8 +: 8] = edge_t[c][k];
  end

  pwm_edge_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_unit_div(cfg_unit_div), .cfg_period(cfg_period),
    .cfg_edge(cfg_edge), .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_idle(cfg_idle),
    .focus_steps(focus_steps), .zoom_steps(zoom_steps),
    .focus_start(focus_start), .zoom_start(zoom_start),
    .pad_out(pad_out), .pad_oe(pad_oe), .focus_busy(focus_busy), .zoom_busy(zoom_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  function automatic logic exp_level(input int c, input int pos);
    logic l = cfg_pol[c];
    for (int k = 0; k < 4; k++) begin
      if (int'(edge_t[c][k]) <= pos) begin
        logic dup = 1'b0;
        for (int j = 0; j < k; j++)
          if (edge_t[c][j] == edge_t[c][k]) dup = 1'b1;
        if (!dup) l = ~l;
      end
    end
    return l;
  endfunction

  task automatic check_pads(input logic fb, input logic zb, input int pos, input string tag);
    for (int c = 0; c < NCH; c++) begin
      logic act, eo, ev;
      act = cfg_en[c] && ((c < 2) ? fb : zb);
      if (act) begin
        eo = 1'b1; ev = exp_level(c, pos);
      end else begin
        case (cfg_idle[2*c +: 2])
          2'b01:   begin eo = 1'b1; ev = 1'b0; end
          2'b10:   begin eo = 1'b1; ev = 1'b1; end
          default: begin eo = 1'b0; ev = 1'b0; end
        endcase
      end
      n_checks++;
      if ({pad_oe[c], pad_out[c]} !== {eo, ev}) begin
        n_errors++;
        $display("FAIL %s ch%0d pos=%0d: actual oe/out=%b%b expected=%b%b",
                 tag, c, pos, pad_oe[c], pad_out[c], eo, ev);
      end
    end
    n_checks++;
    if ({focus_busy, zoom_busy} !== {fb, zb}) begin
      n_errors++;
      $display("FAIL %s busy: actual f/z=%b%b expected=%b%b", tag, focus_busy, zoom_busy, fb, zb);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
  endtask

  // strobe captured at the next edge; returns with cycle 0 sampled
  task automatic pulse_start(input logic f, input logic z);
    focus_start = f;
    zoom_start  = z;
    next_cycle();
    focus_start = 1'b0;
    zoom_start  = 1'b0;
  endtask

  task automatic t_reset();
    // R1 and R7: idle codes hold from reset
    cfg_idle = {2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
    repeat (3) next_cycle();
    check_pads(1'b0, 1'b0, 0, "R1/R7 in reset");
    rst_n = 1'b1;
    repeat (4) next_cycle();
    check_pads(1'b0, 1'b0, 0, "R1/R7 after reset");
  endtask

  task automatic t_focus_move();
    // R2 R3 R4 R5 R6 R10: prescale 2, period 10 positions, 3 periods
    cfg_unit_div = 8'd1;
    cfg_period   = 8'd9;
    focus_steps  = 8'd3;
    cfg_en       = 6'b111111;
    cfg_pol      = 6'b000010;
    edge_t[0] = '{8'd2, 8'd5, 8'd7, 8'd9};
    edge_t[1] = '{8'd6, 8'd3, 8'd3, 8'd8};
    pulse_start(1'b1, 1'b0);
    for (int cyc = 0; cyc <= 64; cyc++) begin
      check_pads(cyc < 60, 1'b0, (cyc / 2) % 10, "R2/R3/R4/R5/R10 focus");
      if (cyc == 59 || cyc == 60) begin
        n_checks++;
        if (focus_busy !== (cyc == 59)) begin
          n_errors++;
          $display("FAIL R6 cyc=%0d: actual busy=%b expected=%b", cyc, focus_busy, cyc == 59);
        end
      end
      next_cycle();
    end
  endtask

  task automatic t_zero_edge();
    // R5 edge at 0; R7 disabled channel inside a moving group
    cfg_unit_div = 8'd0;
    cfg_period   = 8'd7;
    zoom_steps   = 8'd1;
    cfg_en       = 6'b110111;
    cfg_pol      = 6'b100000;
    edge_t[2] = '{8'd0, 8'd4, 8'd4, 8'd9};
    edge_t[5] = '{8'd1, 8'd1, 8'd1, 8'd1};
    pulse_start(1'b0, 1'b1);
    for (int cyc = 0; cyc <= 10; cyc++) begin
      check_pads(1'b0, cyc < 8, cyc % 8, "R5/R7 zoom");
      next_cycle();
    end
  endtask

  task automatic t_overlap();
    // R9 zoom joins at boundary; R8 re-start of running focus ignored
    cfg_unit_div = 8'd0;
    cfg_period   = 8'd7;
    focus_steps  = 8'd2;
    zoom_steps   = 8'd2;
    cfg_en       = 6'b111111;
    edge_t[3] = '{8'd6, 8'd1, 8'd3, 8'd2};
    pulse_start(1'b1, 1'b0);
    for (int cyc = 0; cyc <= 26; cyc++) begin
      check_pads(cyc < 16, cyc >= 8 && cyc < 24, cyc % 8, "R8/R9 overlap");
      zoom_start  = (cyc == 3);
      focus_start = (cyc == 4);
      if (cyc == 4) focus_steps = 8'd5;
      next_cycle();
    end
    focus_start = 1'b0;
    zoom_start  = 1'b0;
  endtask

  task automatic t_zero_steps();
    // R8: zero step count starts nothing
    focus_steps = 8'd0;
    zoom_steps  = 8'd0;
    pulse_start(1'b1, 1'b1);
    for (int cyc = 0; cyc < 4; cyc++) begin
      check_pads(1'b0, 1'b0, 0, "R8 zero steps");
      next_cycle();
    end
  endtask

  initial begin
    rst_n        = 1'b0;
    focus_start  = 1'b0;
    zoom_start   = 1'b0;
    cfg_unit_div = 8'd0;
    cfg_period   = 8'd7;
    focus_steps  = 8'd1;
    zoom_steps   = 8'd1;
    cfg_en       = '0;
    cfg_pol      = '0;
    cfg_idle     = '0;
    for (int c = 0; c < NCH; c++) edge_t[c] = '{8'd1, 8'd2, 8'd3, 8'd4};
    #1;
    t_reset();
    t_focus_move();
    t_zero_edge();
    t_overlap();
    t_zero_steps();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule